// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block sits beside the result storage of an analog-to-digital converter and watches a single result register chosen by a 4-bit select. Each time the converter writes a new result into that register, the block compares the value against a programmable threshold. A direction bit chooses whether "above" or "below" counts as a hit. A hit raises a one-cycle interrupt pulse in the clock after the write.

A monitored register is normally never read by software. For that reason the block reports flag updates for it as though every result went unread: each write to it while monitoring is on sets both its stored flag and its overrun flag. For every other register a write only sets the stored flag. The flag outputs are per-register set pulses that the surrounding status logic ORs into its flag bits. The block does no conversions and no bus decoding.

Top module: `adc_thresh_mon`

## Requirements
- R1: While reset is asserted, and until the reset has been released and synchronized, mon_irq_o is 0 and every bit of stored_set_o and overrun_set_o is 0.
- R2: When mon_en_i is 0 at a write, mon_irq_o stays 0 and overrun_set_o stays all zero in the following cycle, for any index, data or threshold.
- R3: With mon_dir_i = 1 (above), a write to the selected register while enabled whose data is strictly greater than cmp_val_i gives mon_irq_o = 1 in the next cycle; a smaller value gives 0.
- R4: With mon_dir_i = 0 (below), a write to the selected register while enabled whose data is strictly less than cmp_val_i gives mon_irq_o = 1 in the next cycle; a larger value gives 0.
- R5: A written value equal to cmp_val_i never raises mon_irq_o, in either direction.
- R6: A write whose wr_idx_i differs from mon_sel_i never raises mon_irq_o and sets no overrun bit.
- R7: mon_irq_o is a pulse lasting exactly one clock for each qualifying write; consecutive qualifying writes give one pulse per cycle, and the cycle after the last one has mon_irq_o = 0.
- R8: A write to the selected register while enabled pulses overrun_set_o bit wr_idx_i together with stored_set_o bit wr_idx_i in the next cycle, whether or not the comparison hits.
- R9: Every write pulses exactly one bit of stored_set_o, the bit numbered wr_idx_i (bit 0 is register 0), in the next cycle.
- R10: In a cycle after one with wr_valid_i = 0, mon_irq_o, stored_set_o and overrun_set_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid_i | input | 1 | A conversion result is written this cycle |
| wr_idx_i | input | IDX_W (4) | Index of the result register written |
| wr_data_i | input | DATA_W (12) | Result value written |
| mon_en_i | input | 1 | Monitor enable |
| mon_sel_i | input | IDX_W (4) | Index of the monitored result register |
| mon_dir_i | input | 1 | 1: hit when result above threshold; 0: hit when below |
| cmp_val_i | input | DATA_W (12) | Threshold value |
| mon_irq_o | output | 1 | One-cycle monitor interrupt pulse |
| stored_set_o | output | NUM_REGS (16) | Per-register stored-flag set pulses |
| overrun_set_o | output | NUM_REGS (16) | Per-register overrun-flag set pulses |

## Verification
The assertions check on every cycle that an interrupt only follows an enabled write to the selected register, that equality, a disabled monitor or a different index never produce one, that strict above/below hits always do, and that the stored pulses are one-hot with overrun pulses matching them for monitored writes. What the reset state looks like, how the pulses line up over long back-to-back runs, and whether random mixes of direction, select and threshold agree with an independent model are shown only by the bench's scenarios.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  typedef enum logic {
    DIR_BELOW = 1'b0,
    DIR_ABOVE = 1'b1
  } mon_dir_e;
endpackage

// File: rtl/adc_mon_rst_sync.sv
module adc_mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_mon_compare.sv
module adc_mon_compare
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thr_i,
  input  mon_dir_e          dir_i,
  output logic              hit_o
);
  logic above;
  logic below;

  always_comb begin
    above = (data_i > thr_i);
    below = (data_i < thr_i);
    unique case (dir_i)
      DIR_ABOVE: hit_o = above;
      DIR_BELOW: hit_o = below;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_mon_flags.sv
module adc_mon_flags #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                mon_en_i,
  input  logic [IDX_W-1:0]    mon_sel_i,
  output logic [NUM_REGS-1:0] stored_set_o,
  output logic [NUM_REGS-1:0] overrun_set_o
);
  logic [NUM_REGS-1:0] stored_d;
  logic [NUM_REGS-1:0] ovr_d;
  logic [NUM_REGS-1:0] stored_q;
  logic [NUM_REGS-1:0] ovr_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit_idx;
    logic is_mon;
    always_comb begin
      hit_idx     = wr_valid_i && (wr_idx_i == IDX_W'(g));
      is_mon      = mon_en_i && (mon_sel_i == IDX_W'(g));
      stored_d[g] = hit_idx;
      ovr_d[g]    = hit_idx && is_mon;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
      ovr_q    <= '0;
    end else begin
      stored_q <= stored_d;
      ovr_q    <= ovr_d;
    end
  end

  assign stored_set_o  = stored_q;
  assign overrun_set_o = ovr_q;
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
  import adc_mon_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                mon_en_i,
  input  logic [IDX_W-1:0]    mon_sel_i,
  input  logic                mon_dir_i,
  input  logic [DATA_W-1:0]   cmp_val_i,
  output logic                mon_irq_o,
  output logic [NUM_REGS-1:0] stored_set_o,
  output logic [NUM_REGS-1:0] overrun_set_o
);
  logic     rst_sync_n;
  logic     cmp_hit;
  logic     sel_match;
  logic     irq_d;
  logic     irq_q;
  mon_dir_e dir_sel;

  adc_mon_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    dir_sel = mon_dir_e'(mon_dir_i);
  end

  adc_mon_compare #(.DATA_W(DATA_W)) u_cmp (
    .data_i (wr_data_i),
    .thr_i  (cmp_val_i),
    .dir_i  (dir_sel),
    .hit_o  (cmp_hit)
  );

  adc_mon_flags #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_valid_i    (wr_valid_i),
    .wr_idx_i      (wr_idx_i),
    .mon_en_i      (mon_en_i),
    .mon_sel_i     (mon_sel_i),
    .stored_set_o  (stored_set_o),
    .overrun_set_o (overrun_set_o)
  );

  always_comb begin
    sel_match = wr_valid_i && mon_en_i && (wr_idx_i == mon_sel_i);
    irq_d     = sel_match && cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign mon_irq_o = irq_q;
endmodule

// File: rtl/adc_mon_chk.sv
module adc_mon_chk #(
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                wr_valid_i,
  input logic [IDX_W-1:0]    wr_idx_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                mon_en_i,
  input logic [IDX_W-1:0]    mon_sel_i,
  input logic                mon_dir_i,
  input logic [DATA_W-1:0]   cmp_val_i,
  input logic                mon_irq_o,
  input logic [NUM_REGS-1:0] stored_set_o,
  input logic [NUM_REGS-1:0] overrun_set_o
);
  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && !mon_en_i) |=> (!mon_irq_o && overrun_set_o == '0));
  // R3
  above_hit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && mon_en_i && wr_idx_i == mon_sel_i && mon_dir_i && wr_data_i > cmp_val_i)
      |=> mon_irq_o);
  // R4
  below_hit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && mon_en_i && wr_idx_i == mon_sel_i && !mon_dir_i && wr_data_i < cmp_val_i)
      |=> mon_irq_o);
  // R5
  equal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && wr_data_i == cmp_val_i) |=> !mon_irq_o);
  // R6
  other_idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && wr_idx_i != mon_sel_i) |=> (!mon_irq_o && overrun_set_o == '0));
  // R7
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    mon_irq_o |-> $past(wr_valid_i && mon_en_i && wr_idx_i == mon_sel_i));
  // R8
  overrun_pair_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid_i && mon_en_i && wr_idx_i == mon_sel_i)
      |=> (overrun_set_o == stored_set_o && overrun_set_o != '0));
  // R9
  stored_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(stored_set_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_valid_i |=> (!mon_irq_o && stored_set_o == '0 && overrun_set_o == '0));
endmodule

bind adc_thresh_mon adc_mon_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_sync_n),
  .wr_valid_i    (wr_valid_i),
  .wr_idx_i      (wr_idx_i),
  .wr_data_i     (wr_data_i),
  .mon_en_i      (mon_en_i),
  .mon_sel_i     (mon_sel_i),
  .mon_dir_i     (mon_dir_i),
  .cmp_val_i     (cmp_val_i),
  .mon_irq_o     (mon_irq_o),
  .stored_set_o  (stored_set_o),
  .overrun_set_o (overrun_set_o)
);

// File: tb/adc_thresh_mon_tb.sv
`timescale 1ns/1ps
module adc_thresh_mon_tb;
  localparam int DATA_W   = 12;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                wr_valid_i;
  logic [IDX_W-1:0]    wr_idx_i;
  logic [DATA_W-1:0]   wr_data_i;
  logic                mon_en_i;
  logic [IDX_W-1:0]    mon_sel_i;
  logic                mon_dir_i;
  logic [DATA_W-1:0]   cmp_val_i;
  logic                mon_irq_o;
  logic [NUM_REGS-1:0] stored_set_o;
  logic [NUM_REGS-1:0] overrun_set_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_thresh_mon #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .mon_en_i(mon_en_i), .mon_sel_i(mon_sel_i),
    .mon_dir_i(mon_dir_i), .cmp_val_i(cmp_val_i), .mon_irq_o(mon_irq_o),
    .stored_set_o(stored_set_o), .overrun_set_o(overrun_set_o)
  );

  function automatic logic exp_irq(logic v, logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d,
                                   logic en, logic [IDX_W-1:0] sel, logic dir,
                                   logic [DATA_W-1:0] c);
    if (!v || !en || idx != sel) return 1'b0;
    return dir ? (d > c) : (d < c);
  endfunction

  function automatic logic [NUM_REGS-1:0] exp_stored(logic v, logic [IDX_W-1:0] idx);
    return v ? (NUM_REGS'(1) << idx) : '0;
  endfunction

  function automatic logic [NUM_REGS-1:0] exp_ovr(logic v, logic [IDX_W-1:0] idx,
                                                  logic en, logic [IDX_W-1:0] sel);
    return (v && en && idx == sel) ? (NUM_REGS'(1) << idx) : '0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, check the registered result one edge later.
  task automatic step(logic v, logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d, logic en,
                      logic [IDX_W-1:0] sel, logic dir, logic [DATA_W-1:0] c);
    string tag;
    logic ei;
    logic [NUM_REGS-1:0] es, eo;
    wr_valid_i = v; wr_idx_i = idx; wr_data_i = d;
    mon_en_i = en; mon_sel_i = sel; mon_dir_i = dir; cmp_val_i = c;
    ei = exp_irq(v, idx, d, en, sel, dir, c);
    es = exp_stored(v, idx);
    eo = exp_ovr(v, idx, en, sel);
    if (!v)              tag = "R10";
    else if (idx != sel) tag = "R6";
    else if (!en)        tag = "R2";
    else if (d == c)     tag = "R5";
    else if (dir)        tag = "R3";
    else                 tag = "R4";
    @(negedge clk);
    check(mon_irq_o == ei, tag, "irq", 32'(mon_irq_o), 32'(ei));
    check(stored_set_o == es, "R9", "stored_set", 32'(stored_set_o), 32'(es));
    check(overrun_set_o == eo, "R8", "overrun_set", 32'(overrun_set_o), 32'(eo));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wr_valid_i = 0; wr_idx_i = 0; wr_data_i = 0;
    mon_en_i = 0; mon_sel_i = 0; mon_dir_i = 0; cmp_val_i = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mon_irq_o == 1'b0, "R1", "irq in reset", 32'(mon_irq_o), 0);
    check(stored_set_o == '0, "R1", "stored in reset", 32'(stored_set_o), 0);
    check(overrun_set_o == '0, "R1", "overrun in reset", 32'(overrun_set_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners
    step(1, 4'd5, 12'd801, 1, 4'd5, 1, 12'd800);   // R3 above by one
    step(1, 4'd5, 12'd799, 1, 4'd5, 1, 12'd800);   // R3 below gives no hit
    step(1, 4'd5, 12'd800, 1, 4'd5, 1, 12'd800);   // R5 equal, above
    step(1, 4'd5, 12'd800, 1, 4'd5, 0, 12'd800);   // R5 equal, below
    step(1, 4'd2, 12'd0,   1, 4'd2, 0, 12'd1);     // R4 below
    step(1, 4'd2, 12'd4095,1, 4'd2, 0, 12'd4094);  // R4 above gives no hit
    step(1, 4'd3, 12'd4095,1, 4'd9, 1, 12'd0);     // R6 other index
    step(1, 4'd9, 12'd4095,0, 4'd9, 1, 12'd0);     // R2 disabled
    step(1, 4'd15,12'd100, 1, 4'd15,1, 12'd10);    // R7 back-to-back pulses
    step(1, 4'd15,12'd200, 1, 4'd15,1, 12'd10);
    step(1, 4'd15,12'd300, 1, 4'd15,1, 12'd10);
    step(0, 4'd15,12'd400, 1, 4'd15,1, 12'd10);    // R7 pulse ends, R10 idle
    step(1, 4'd0, 12'd1,   1, 4'd0, 1, 12'd0);     // R8 register 0
    step(0, 4'd0, 12'd1,   1, 4'd0, 1, 12'd0);

    // Constrained random: select biased toward the monitored index
    for (int i = 0; i < 3000; i++) begin
      logic v, en, dir;
      logic [IDX_W-1:0] sel, idx;
      logic [DATA_W-1:0] c, d;
      v   = ($urandom % 8) != 0;
      en  = ($urandom % 4) != 0;
      dir = $urandom % 2;
      sel = IDX_W'($urandom);
      idx = (($urandom % 3) != 0) ? sel : IDX_W'($urandom);
      c   = DATA_W'($urandom);
      case ($urandom % 4)
        0: d = c;
        1: d = c + DATA_W'(1);
        2: d = c - DATA_W'(1);
        default: d = DATA_W'($urandom);
      endcase
      step(v, idx, d, en, sel, dir, c);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule